// File: doc/BRIEF.md
# Randomized-Mapping Secure Cache

This block is a data cache in which the placement of a memory block in the physical line array is not fixed. Each physical line keeps a line-number register that holds an extended index: the usual index plus a few extra bits. A lookup compares the request's extended index against every line-number register in parallel, in the manner of a content-addressable match. It also compares the stored tag of the line that matched. A request hits only when both comparisons succeed.

When a request misses and no line holds its extended index, a pseudo-random generator picks the line to evict. That line's line-number register is then rewritten with the new extended index. As a result, the line a victim displaces says nothing about the address the victim used. When a line already holds the extended index but its tag differs, that line is replaced in place. A dirty victim is written back to memory before the refill is requested. The CPU port stalls for the whole miss sequence, and only one miss is in flight at a time.

The CPU side accepts one word access per handshake and returns a one-cycle response carrying the read data and a hit flag. The memory side moves whole lines with a request/acknowledge pair. The random generator runs freely and can be reseeded at run time.

Top module: `secache_top`

## Requirements
- R1: The address splits, from the least significant bit up, into a byte offset of log2(line bytes) bits, an extended index of log2(lines)+extra bits, and a tag made of the remaining upper bits. Inside the offset, the bits above the byte-in-word bits select the word. Word w of a line sits at line bits [w*word_width +: word_width].
- R2: After reset every line is invalid. The CPU port is ready, no response is pending and no memory request is raised. The first access to any address therefore misses.
- R3: Line-number registers reset to distinct values (line i holds i). No extended index is ever held by two lines at once.
- R4: A request is a hit only when the extended index matches a line-number register and the same line is valid with an equal tag. A hit accepted in cycle c gives a response in cycle c+2.
- R5: If the extended index matches a line but the tag does not, that same line is refilled in place, so the earlier block held there is gone.
- R6: If no line-number register matches, the victim line is taken from the random generator modulo the line count. Its line-number register is rewritten with the request's extended index.
- R7: A valid dirty victim is written to memory (mem_we=1, line address {stored tag, line-number register}, whole line as data) before the refill read is issued. Request signals hold steady until acknowledged.
- R8: cpu_ready is low from acceptance until the response. The response lasts one cycle.
- R9: A write hit replaces the selected word and marks the line dirty. Later reads return the newest value written.
- R10: The 16-bit random state advances every cycle. rng_seed_load replaces it with rng_seed, except that a zero seed is replaced by a fixed nonzero value. Equal seeds after equal resets give equal hit/miss histories.
- R11: A miss completes with a response whose hit flag is 0 and whose data is the correct word, more than two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rng_seed_load | input | 1 | Load rng_seed into the random generator |
| rng_seed | input | 16 | Seed value |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | WORD_W | Write word |
| cpu_resp_valid | output | 1 | Response valid (one cycle) |
| cpu_resp_hit | output | 1 | 1 when the request hit without a refill |
| cpu_rdata | output | WORD_W | Read word |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = writeback, 0 = refill read |
| mem_addr | output | ADDR_W-log2(LINE_BYTES) | Line address |
| mem_wdata | output | LINE_BYTES*8 | Writeback line |
| mem_ack | input | 1 | Memory completes the transfer |
| mem_rdata | input | LINE_BYTES*8 | Refill line, valid with mem_ack |

## Verification
The bench runs an eight-line configuration and targets the index-hit/tag-miss case. A design that evicted a random line there instead would leave two lines holding one extended index, and the old block would keep hitting. It checks that a dirty line is written back, with its own address and its modified word, before the refill. A design that refilled first or wrote the wrong address would corrupt later reads. A sweep over many extended indices requires both survivals and evictions of an unrelated block: a fixed victim choice or a fixed mapping fails one of the two. Reseeding with equal and zero seeds catches a generator that ignores the load or locks up at zero.

// File: rtl/secache_pkg.sv
package secache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL
  } sc_state_e;

  localparam int              RNG_W       = 16;
  localparam logic [RNG_W-1:0] RNG_TAPS    = 16'hB400;
  localparam logic [RNG_W-1:0] RNG_ALTSEED = 16'h1D2B;

  // Galois shift step of the victim generator
  function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
    return s[0] ? ((s >> 1) ^ RNG_TAPS) : (s >> 1);
  endfunction

  // A zero state would lock the generator, so it is swapped out
  function automatic logic [RNG_W-1:0] rng_fix(input logic [RNG_W-1:0] s);
    return (s == '0) ? RNG_ALTSEED : s;
  endfunction

endpackage

// File: rtl/secache_rng.sv
module secache_rng
  import secache_pkg::*;
#(
  parameter logic [RNG_W-1:0] RST_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RNG_W-1:0] seed,
  output logic [RNG_W-1:0] state_o
);

  logic [RNG_W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= rng_fix(RST_SEED);
    else if (load) st_q <= rng_fix(seed);
    else           st_q <= rng_step(st_q);
  end

  assign state_o = st_q;

endmodule

// File: rtl/secache_lnmap.sv
module secache_lnmap #(
  parameter int LINES  = 512,
  parameter int IDX_W  = 9,
  parameter int EIDX_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EIDX_W-1:0] key,
  output logic [LINES-1:0]  match_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [EIDX_W-1:0] rd_val,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [EIDX_W-1:0] wr_val
);

  logic [EIDX_W-1:0] ln_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) ln_q[i] <= EIDX_W'(i);
    end else if (wr_en) begin
      ln_q[wr_idx] <= wr_val;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match_o[g] = (ln_q[g] == key);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match_o[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o  = |match_o;
  assign rd_val = ln_q[rd_idx];

endmodule

// File: rtl/secache_lines.sv
module secache_lines #(
  parameter int LINES  = 512,
  parameter int IDX_W  = 9,
  parameter int TAG_W  = 13,
  parameter int LINE_W = 512,
  parameter int WORD_W = 32,
  parameter int WSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_word
);

  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= 1'b0;
    end else if (wr_en) begin
      dirty_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_line;
    end else if (wr_en) begin
      data_q[wr_idx][wr_sel*WORD_W +: WORD_W] <= wr_word;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = data_q[rd_idx];

endmodule

// File: rtl/secache_top.sv
module secache_top
  import secache_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              WORD_W     = 32,
  parameter int              LINE_BYTES = 64,
  parameter int              LINES      = 512,
  parameter int              EXTRA_IDX  = 4,
  parameter logic [RNG_W-1:0] RNG_SEED   = 16'hACE1,
  localparam int             OFF_W      = $clog2(LINE_BYTES),
  localparam int             LADDR_W    = ADDR_W - OFF_W,
  localparam int             LINE_W     = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rng_seed_load,
  input  logic [RNG_W-1:0]   rng_seed,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  output logic               cpu_resp_valid,
  output logic               cpu_resp_hit,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [LINE_W-1:0]  mem_rdata
);

  localparam int WB_W   = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - WB_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int EIDX_W = IDX_W + EXTRA_IDX;
  localparam int TAG_W  = ADDR_W - OFF_W - EIDX_W;

  // ---------------- address arithmetic ----------------
  function automatic logic [EIDX_W-1:0] f_eidx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: EIDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] f_wsel(input logic [ADDR_W-1:0] a);
    return a[WB_W +: WSEL_W];
  endfunction
  function automatic logic [LADDR_W-1:0] f_laddr(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic logic [WORD_W-1:0] f_pick(input logic [LINE_W-1:0] l,
                                              input logic [WSEL_W-1:0] s);
    return l[s*WORD_W +: WORD_W];
  endfunction
  function automatic logic [IDX_W-1:0] f_victim(input logic [RNG_W-1:0] r);
    return IDX_W'(r % RNG_W'(LINES));
  endfunction

  // ---------------- state ----------------
  sc_state_e         state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [WORD_W-1:0] req_wdata_q;
  logic [IDX_W-1:0]  vic_q;
  logic              remap_q;
  logic              missed_q;
  logic              resp_valid_q, resp_hit_q;
  logic [WORD_W-1:0] rdata_q;

  // ---------------- named internal events ----------------
  logic [RNG_W-1:0]  rng_q;
  logic [LINES-1:0]  idx_match;
  logic              idx_hit;
  logic [IDX_W-1:0]  idx_line;
  logic [IDX_W-1:0]  vic_comb, sel_idx;
  logic [EIDX_W-1:0] sel_ln;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic              tag_hit, lookup_hit, lookup_miss, wb_need;
  logic              fill_en, remap_en, word_wr;
  logic [EIDX_W-1:0] look_eidx;
  logic [TAG_W-1:0]  look_tag;

  assign look_eidx = f_eidx(req_addr_q);
  assign look_tag  = f_tag(req_addr_q);

  secache_rng #(.RST_SEED(RNG_SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .load(rng_seed_load), .seed(rng_seed), .state_o(rng_q)
  );

  secache_lnmap #(.LINES(LINES), .IDX_W(IDX_W), .EIDX_W(EIDX_W)) u_map (
    .clk(clk), .rst_n(rst_n), .key(look_eidx),
    .match_o(idx_match), .hit_o(idx_hit), .hit_idx_o(idx_line),
    .rd_idx(sel_idx), .rd_val(sel_ln),
    .wr_en(remap_en), .wr_idx(vic_q), .wr_val(look_eidx)
  );

  // in-place line on index hit, random line otherwise
  assign vic_comb = idx_hit ? idx_line : f_victim(rng_q);
  assign sel_idx  = (state_q == ST_LOOK) ? vic_comb : vic_q;

  secache_lines #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .LINE_W(LINE_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_n), .rd_idx(sel_idx),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_line(rd_line),
    .fill_en(fill_en), .fill_idx(vic_q), .fill_tag(look_tag), .fill_line(mem_rdata),
    .wr_en(word_wr), .wr_idx(idx_line), .wr_sel(f_wsel(req_addr_q)), .wr_word(req_wdata_q)
  );

  assign tag_hit     = idx_hit && rd_valid && (rd_tag == look_tag);
  assign lookup_hit  = (state_q == ST_LOOK) && tag_hit;
  assign lookup_miss = (state_q == ST_LOOK) && !tag_hit;
  assign wb_need     = rd_valid && rd_dirty;
  assign fill_en     = (state_q == ST_FILL) && mem_ack;
  assign remap_en    = fill_en && remap_q;
  assign word_wr     = lookup_hit && req_we_q;

  // ---------------- memory port ----------------
  assign mem_req   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? {rd_tag, sel_ln} : f_laddr(req_addr_q);
  assign mem_wdata = rd_line;

  // ---------------- control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      req_addr_q   <= '0;
      req_we_q     <= 1'b0;
      req_wdata_q  <= '0;
      vic_q        <= '0;
      remap_q      <= 1'b0;
      missed_q     <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      rdata_q      <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cpu_valid) begin
          req_addr_q  <= cpu_addr;
          req_we_q    <= cpu_we;
          req_wdata_q <= cpu_wdata;
          missed_q    <= 1'b0;
          state_q     <= ST_LOOK;
        end
        ST_LOOK: if (lookup_hit) begin
          resp_valid_q <= 1'b1;
          resp_hit_q   <= !missed_q;
          rdata_q      <= req_we_q ? req_wdata_q : f_pick(rd_line, f_wsel(req_addr_q));
          state_q      <= ST_IDLE;
        end else if (lookup_miss) begin
          vic_q    <= vic_comb;
          remap_q  <= !idx_hit;
          missed_q <= 1'b1;
          state_q  <= wb_need ? ST_WB : ST_FILL;
        end
        ST_WB:   if (mem_ack) state_q <= ST_FILL;
        ST_FILL: if (mem_ack) state_q <= ST_LOOK;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready      = (state_q == ST_IDLE);
  assign cpu_resp_valid = resp_valid_q;
  assign cpu_resp_hit   = resp_hit_q;
  assign cpu_rdata      = rdata_q;

endmodule

// File: rtl/secache_chk.sv
module secache_chk #(
  parameter int LINES   = 512,
  parameter int LADDR_W = 26,
  parameter int RNG_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LINES-1:0]   idx_match,
  input logic               lookup_hit,
  input logic [RNG_W-1:0]   rng_q,
  input logic               cpu_ready,
  input logic               cpu_resp_valid,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [LADDR_W-1:0] mem_addr
);

  assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(idx_match));

  assert_hit_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> cpu_resp_valid);

  assert_resp_from_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> $past(lookup_hit));

  assert_stall_during_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  assert_single_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |=> !cpu_resp_valid);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  assert_rng_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rng_q != '0);

endmodule

bind secache_top secache_chk #(
  .LINES(LINES), .LADDR_W(LADDR_W), .RNG_W(secache_pkg::RNG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .idx_match(idx_match), .lookup_hit(lookup_hit),
  .rng_q(rng_q), .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/tb_secache_top.sv
`timescale 1ns/1ps
module tb_secache_top;

  // small configuration: 8 lines of 8 bytes, 2 extra index bits, 16-bit address
  // offset [2:0] (word select = bit 2), extended index [7:3], tag [15:8]
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rng_seed_load = 1'b0;
  logic [15:0] rng_seed = '0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_resp_valid, cpu_resp_hit;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [12:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  secache_top #(
    .ADDR_W(16), .WORD_W(32), .LINE_BYTES(8), .LINES(8), .EXTRA_IDX(2)
  ) dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic [63:0] mem_m [8192];
  logic [31:0] gold  [16384];
  int ev_w, ev_f, order_bad;
  logic [12:0] last_wb;

  function automatic logic [31:0] init_word(int w);
    return (32'(w) * 32'h9E37) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [15:0] mk(int tag, int eidx, int off);
    return {tag[7:0], eidx[4:0], off[2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges one cycle after a request is seen
  initial begin
    for (int a = 0; a < 8192; a++) mem_m[a] = {init_word(2*a+1), init_word(2*a)};
    for (int w = 0; w < 16384; w++) gold[w] = init_word(w);
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          ev_w++;
          if (ev_f != 0) order_bad = 1;
          last_wb = mem_addr;
          check(mem_wdata == {gold[{mem_addr,1'b1}], gold[{mem_addr,1'b0}]}, "R7",
                "writeback line data", mem_wdata, {gold[{mem_addr,1'b1}], gold[{mem_addr,1'b0}]});
          mem_m[mem_addr] = mem_wdata;
        end else begin
          ev_f++;
          mem_rdata = mem_m[mem_addr];
        end
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic do_op(input bit we, input logic [15:0] a, input logic [31:0] wd,
                       output bit hit, output int lat);
    bit busy_bad;
    logic [31:0] exp;
    exp = gold[a[15:2]];
    ev_w = 0; ev_f = 0; order_bad = 0; busy_bad = 0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    lat = 1;
    while (!cpu_resp_valid && lat < 200) begin
      if (cpu_ready) busy_bad = 1;
      @(negedge clk);
      lat++;
    end
    hit = cpu_resp_hit;
    check(!busy_bad, "R8", "ready low while busy", 64'(busy_bad), 0);
    check(order_bad == 0, "R7", "writeback before refill", 64'(order_bad), 0);
    if (!we) check(cpu_rdata == exp, "R9", "read data", cpu_rdata, exp);
    else gold[a[15:2]] = wd;
    @(negedge clk);
    check(!cpu_resp_valid, "R8", "one-cycle response", 64'(cpu_resp_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int w = 0; w < 16384; w++) gold[w] = w[0] ? mem_m[w >> 1][63:32] : mem_m[w >> 1][31:0];
    rst_n = 1'b1;
  endtask

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk); rng_seed_load = 1'b1; rng_seed = s;
    @(negedge clk); rng_seed_load = 1'b0;
  endtask

  task automatic pattern(output logic [17:0] v);
    bit h; int l;
    for (int i = 0; i < 12; i++) begin
      do_op(0, mk(40+i, 8 + (i*5)%24, 0), 0, h, l); v[i] = h;
    end
    for (int i = 0; i < 6; i++) begin
      do_op(0, mk(40+i, 8 + (i*5)%24, 0), 0, h, l); v[12+i] = h;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    bit h; int l; int survive, evict, hits;
    logic [17:0] v1, v2;
    logic [15:0] a0, b0;
    do_reset();
    @(negedge clk);
    // R2: reset state
    check(cpu_ready && !cpu_resp_valid && !mem_req, "R2", "reset port state",
          {cpu_ready, cpu_resp_valid, mem_req}, 3'b100);
    load_seed(16'h3C5A);

    a0 = mk(1, 3, 0);
    do_op(0, a0, 0, h, l);
    check(!h, "R2", "first access misses", h, 0);
    check(l > 2 && ev_f == 1 && ev_w == 0, "R11", "miss latency/refill count", l, 3);
    do_op(0, a0, 0, h, l);
    check(h && l == 2, "R4", "hit with two-cycle latency", {h, l[7:0]}, {1'b1, 8'd2});

    // R1: every byte offset of the line selects the right word
    for (int off = 0; off < 8; off++) begin
      do_op(0, mk(1, 3, off), 0, h, l);
      check(h, "R1", "offset within filled line hits", h, 1);
    end

    // R9: write hit then read back
    do_op(1, mk(1, 3, 4), 32'hDEADBEEF, h, l);
    check(h, "R9", "write hit", h, 1);
    do_op(0, mk(1, 3, 5), 0, h, l);
    check(cpu_rdata == 32'hDEADBEEF, "R9", "read back written word", cpu_rdata, 32'hDEADBEEF);

    // R5/R3/R7: same extended index, new tag -> in-place refill, dirty writeback
    b0 = mk(2, 3, 0);
    do_op(0, b0, 0, h, l);
    check(!h && ev_w == 1 && ev_f == 1, "R7", "dirty victim written then refilled",
          {ev_w[3:0], ev_f[3:0]}, 8'h11);
    check(last_wb == a0[15:3], "R7", "writeback line address", last_wb, a0[15:3]);
    do_op(0, a0, 0, h, l);
    check(!h && ev_w == 0, "R5", "old block replaced in place (R3 single owner)", {h, ev_w[3:0]}, 0);
    do_op(0, a0, 0, h, l);
    check(h, "R3", "refetched block hits", h, 1);

    // R6: random victims - an unrelated index must sometimes evict, sometimes not
    survive = 0; evict = 0;
    for (int t = 0; t < 32; t++) begin
      do_op(t[0], mk(10+t, 8 + t%24, 0), 32'h1000 + 32'(t), h, l);
      for (int j = 0; j < 3; j++) do_op(0, mk(200+t, 8 + (t+1+j)%24, 4), 0, h, l);
      do_op(0, mk(10+t, 8 + t%24, 4), 0, h, l);
      if (h) survive++; else evict++;
    end
    check(survive > 0, "R6", "unrelated fills leave block resident sometimes", survive, 1);
    check(evict > 0, "R6", "unrelated fills evict block sometimes", evict, 1);

    // R10: equal seeds after reset give equal histories
    do_reset(); load_seed(16'hACE1); pattern(v1);
    do_reset(); load_seed(16'hACE1); pattern(v2);
    check(v1 == v2, "R10", "repeatable with equal seed", v2, v1);

    // R10: zero seed does not lock victim choice
    do_reset(); load_seed(16'h0000);
    for (int i = 0; i < 6; i++) do_op(0, mk(90+i, 10+i, 0), 0, h, l);
    hits = 0;
    for (int i = 5; i >= 0; i--) begin
      do_op(0, mk(90+i, 10+i, 0), 0, h, l);
      if (h) hits++;
    end
    check(hits >= 2, "R10", "zero seed replaced by working value", hits, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule